// File: doc/BRIEF.md
# DRAM Column Read Burst Engine

This block is a synthesizable behavioural model of the column read path of a single DRAM bank. A small row-data array is filled through a write port. A read command names a column. When the command is accepted, the eight-word chunk that holds that column is copied into a prefetch slot, already rearranged into the order the burst will use. After a column latency, measured in clock cycles, the slot streams out at two words per rising edge. The two words travel on an even lane and an odd lane, which stands in for double-data-rate transfer. In chopped mode only half of the chunk is sent.

The column latency comes from a configuration input and is captured once after reset. Each command travels down a shift pipeline and carries a prefetch slot index. This lets several reads be in flight at once. Reads issued at the minimum column-to-column spacing of four cycles produce bursts with no gap between them.

Top module: `dram_col_burst`

## Requirements
- R1: A read of column `c` returns only words from the aligned eight-word chunk `c[5:3]*8 .. c[5:3]*8+7`. A row-store write places `ld_data` at column `ld_addr` on the rising edge where `ld_en` is high.
- R2: Burst position `p` (0..7) carries chunk word `{c[2]^p[2], (c[1:0]+p[1:0]) mod 4}`. For example, start 1 gives 1,2,3,0,5,6,7,4 and start 6 gives 6,7,4,5,2,3,0,1.
- R3: Let E be the rising edge that accepts a read, and CL the captured latency. Positions 2b (even lane) and 2b+1 (odd lane) appear after edge E+CL+b, with both valid flags high. A full burst lasts four consecutive cycles, b = 0..3.
- R4: When `rd_chop` is 1, only positions 0..3 are sent, over two cycles. The valid flags then drop unless another burst follows.
- R5: The latency is taken from `cfg_cl` on the first rising edge after reset is released. Values below 5 become 5 and values above 16 become 16. Later changes to `cfg_cl` have no effect until the next reset.
- R6: A read presented on that first capture edge is ignored and produces no output.
- R7: Row-store writes made after a read's accepting edge do not change the data of that read's burst.
- R8: Reads accepted four cycles apart produce bursts that follow each other with no idle cycle. Up to four reads may be in flight.
- R9: Both valid flags are low during reset and in every cycle not covered by R3/R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl | input | 5 | Column latency setting, captured after reset |
| ld_en | input | 1 | Row-store write enable |
| ld_addr | input | 6 | Row-store write column |
| ld_data | input | 16 | Row-store write word |
| rd_valid | input | 1 | Read command present |
| rd_col | input | 6 | Read column address |
| rd_chop | input | 1 | 1 = four-word chopped burst |
| dq_even | output | 16 | Even-lane word (position 2b) |
| dq_even_vld | output | 1 | Even-lane valid |
| dq_odd | output | 16 | Odd-lane word (position 2b+1) |
| dq_odd_vld | output | 1 | Odd-lane valid |

## Verification
The assertions assume that read commands are accepted no closer than four cycles apart, which is the minimum column-to-column spacing. Both the burst-length and the quiet-output properties rely on this. The stimulus issues every read through one task that waits at least four cycles before the next command. The stimulus also lets the scoreboard drain before it resets the block or changes the latency setting, so expected beats never straddle two latency values.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int BURST_LEN = 8;
  localparam int TCCD      = 4;

  // chunk word carried at burst position pos for a read starting at start
  function automatic logic [2:0] burst_word(input logic [2:0] start, input logic [2:0] pos);
    logic [1:0] rot;
    rot = start[1:0] + pos[1:0];
    return {start[2] ^ pos[2], rot};
  endfunction
endpackage

// File: rtl/dcb_row_store.sv
module dcb_row_store #(
  parameter int W    = 16,
  parameter int COLS = 64,
  localparam int AW  = $clog2(COLS)
) (
  input  logic                                   clk,
  input  logic                                   we,
  input  logic [AW-1:0]                          waddr,
  input  logic [W-1:0]                           wdata,
  input  logic [AW-4:0]                          chunk_sel,
  output logic [dcb_pkg::BURST_LEN-1:0][W-1:0]   chunk_o
);
  logic [W-1:0] mem_q [COLS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  for (genvar i = 0; i < dcb_pkg::BURST_LEN; i++) begin : g_chunk
    assign chunk_o[i] = mem_q[{chunk_sel, 3'(i)}];
  end
endmodule

// File: rtl/dcb_prefetch.sv
module dcb_prefetch #(
  parameter int W      = 16,
  parameter int SLOT_W = 3,
  localparam int NSLOT = 1 << SLOT_W
) (
  input  logic                                 clk,
  input  logic                                 wr_en,
  input  logic [SLOT_W-1:0]                    wr_slot,
  input  logic [2:0]                           wr_start,
  input  logic [dcb_pkg::BURST_LEN-1:0][W-1:0] chunk_i,
  input  logic [SLOT_W-1:0]                    rd_slot,
  input  logic [1:0]                           rd_pair,
  output logic [W-1:0]                         rd_even,
  output logic [W-1:0]                         rd_odd
);
  logic [dcb_pkg::BURST_LEN-1:0][W-1:0] pf_mem [NSLOT];

  // store the chunk already in burst order
  for (genvar p = 0; p < dcb_pkg::BURST_LEN; p++) begin : g_pos
    logic [W-1:0] word_d;
    assign word_d = chunk_i[dcb_pkg::burst_word(wr_start, 3'(p))];
    always_ff @(posedge clk) begin
      if (wr_en) pf_mem[wr_slot][p] <= word_d;
    end
  end

  assign rd_even = pf_mem[rd_slot][{rd_pair, 1'b0}];
  assign rd_odd  = pf_mem[rd_slot][{rd_pair, 1'b1}];
endmodule

// File: rtl/dcb_cmd_delay.sv
module dcb_cmd_delay #(
  parameter int DEPTH  = 16,
  parameter int DW     = 4,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [DW-1:0]    in_d,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tap_v,
  output logic [DW-1:0]    tap_d
);
  logic [DEPTH-1:0]         vld_q, vld_d;
  logic [DEPTH-1:0][DW-1:0] pay_q, pay_d;

  always_comb begin
    vld_d = {vld_q[DEPTH-2:0], in_v};
    pay_d = {pay_q[DEPTH-2:0], in_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    pay_q <= pay_d;
  end

  assign tap_v = vld_q[tap_sel];
  assign tap_d = pay_q[tap_sel];
endmodule

// File: rtl/dcb_burst_seq.sv
module dcb_burst_seq #(
  parameter int W      = 16,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_vld,
  input  logic              tap_chop,
  input  logic [SLOT_W-1:0] tap_slot,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [1:0]        rd_pair,
  input  logic [W-1:0]      rd_even,
  input  logic [W-1:0]      rd_odd,
  output logic [W-1:0]      q_even,
  output logic              q_vld_e,
  output logic [W-1:0]      q_odd,
  output logic              q_vld_o
);
  logic              act_q, act_d;
  logic              chop_q, chop_d;
  logic [1:0]        beat_q, beat_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              vld_d, last_beat, data_en;
  logic [W-1:0]      even_q, odd_q;
  logic              vld_e_q, vld_o_q;

  assign rd_slot   = tap_vld ? tap_slot : slot_q;
  assign rd_pair   = tap_vld ? 2'd0 : beat_q;
  assign last_beat = chop_q ? (beat_q == 2'd1) : (beat_q == 2'd3);

  always_comb begin
    act_d  = act_q;
    chop_d = chop_q;
    beat_d = beat_q;
    slot_d = slot_q;
    vld_d  = 1'b0;
    if (tap_vld) begin
      act_d  = 1'b1;
      chop_d = tap_chop;
      beat_d = 2'd1;
      slot_d = tap_slot;
      vld_d  = 1'b1;
    end else if (act_q) begin
      act_d  = !last_beat;
      beat_d = beat_q + 2'd1;
      vld_d  = 1'b1;
    end
  end

  assign data_en = vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      chop_q  <= 1'b0;
      beat_q  <= 2'd0;
      slot_q  <= '0;
      vld_e_q <= 1'b0;
      vld_o_q <= 1'b0;
      even_q  <= '0;
      odd_q   <= '0;
    end else begin
      act_q   <= act_d;
      chop_q  <= chop_d;
      beat_q  <= beat_d;
      slot_q  <= slot_d;
      vld_e_q <= vld_d;
      vld_o_q <= vld_d;
      if (data_en) begin
        even_q <= rd_even;
        odd_q  <= rd_odd;
      end
    end
  end

  assign q_even  = even_q;
  assign q_odd   = odd_q;
  assign q_vld_e = vld_e_q;
  assign q_vld_o = vld_o_q;

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tap_vld |=> (q_vld_e && q_vld_o)); // R3
  AST_CHOP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tap_vld && tap_chop, 2) && !$past(tap_vld) && !tap_vld) |=> !(q_vld_e || q_vld_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tap_vld && !act_q) |=> !(q_vld_e || q_vld_o)); // R9
endmodule

// File: rtl/dram_col_burst.sv
module dram_col_burst #(
  parameter int W      = 16,
  parameter int COLS   = 64,
  parameter int CL_MIN = 5,
  parameter int CL_MAX = 16,
  localparam int AW     = $clog2(COLS),
  localparam int CLW    = $clog2(CL_MAX + 1),
  localparam int TAP_W  = $clog2(CL_MAX),
  localparam int SLOT_W = $clog2(CL_MAX / dcb_pkg::TCCD + 2),
  localparam int DW     = 1 + SLOT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CLW-1:0] cfg_cl,
  input  logic           ld_en,
  input  logic [AW-1:0]  ld_addr,
  input  logic [W-1:0]   ld_data,
  input  logic           rd_valid,
  input  logic [AW-1:0]  rd_col,
  input  logic           rd_chop,
  output logic [W-1:0]   dq_even,
  output logic           dq_even_vld,
  output logic [W-1:0]   dq_odd,
  output logic           dq_odd_vld
);
  logic [CLW-1:0]    cl_q, cl_d, cl_clamped;
  logic              cl_ok_q;
  logic              accept;
  logic [SLOT_W-1:0] wptr_q, wptr_d;
  logic [dcb_pkg::BURST_LEN-1:0][W-1:0] chunk;
  logic              tap_v;
  logic [DW-1:0]     tap_d;
  logic [SLOT_W-1:0] rd_slot;
  logic [1:0]        rd_pair;
  logic [W-1:0]      pf_even, pf_odd;
  logic [TAP_W-1:0]  tap_sel;

  always_comb begin
    if (cfg_cl < CLW'(CL_MIN))      cl_clamped = CLW'(CL_MIN);
    else if (cfg_cl > CLW'(CL_MAX)) cl_clamped = CLW'(CL_MAX);
    else                            cl_clamped = cfg_cl;
    cl_d   = cl_ok_q ? cl_q : cl_clamped;
    accept = rd_valid && cl_ok_q;
    wptr_d = accept ? wptr_q + 1'b1 : wptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q    <= CLW'(CL_MIN);
      cl_ok_q <= 1'b0;
      wptr_q  <= '0;
    end else begin
      cl_q    <= cl_d;
      cl_ok_q <= 1'b1;
      wptr_q  <= wptr_d;
    end
  end

  assign tap_sel = TAP_W'(cl_q - 1'b1);

  dcb_row_store #(.W(W), .COLS(COLS)) i_store (
    .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .chunk_sel(rd_col[AW-1:3]), .chunk_o(chunk)
  );

  dcb_prefetch #(.W(W), .SLOT_W(SLOT_W)) i_prefetch (
    .clk(clk), .wr_en(accept), .wr_slot(wptr_q), .wr_start(rd_col[2:0]),
    .chunk_i(chunk), .rd_slot(rd_slot), .rd_pair(rd_pair),
    .rd_even(pf_even), .rd_odd(pf_odd)
  );

  dcb_cmd_delay #(.DEPTH(CL_MAX), .DW(DW)) i_delay (
    .clk(clk), .rst_n(rst_n), .in_v(accept), .in_d({rd_chop, wptr_q}),
    .tap_sel(tap_sel), .tap_v(tap_v), .tap_d(tap_d)
  );

  dcb_burst_seq #(.W(W), .SLOT_W(SLOT_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .tap_vld(tap_v), .tap_chop(tap_d[DW-1]),
    .tap_slot(tap_d[SLOT_W-1:0]), .rd_slot(rd_slot), .rd_pair(rd_pair),
    .rd_even(pf_even), .rd_odd(pf_odd), .q_even(dq_even), .q_vld_e(dq_even_vld),
    .q_odd(dq_odd), .q_vld_o(dq_odd_vld)
  );

  // spacing monitor for the column-to-column rule
  logic [2:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            gap_q <= 3'(dcb_pkg::TCCD);
    else if (accept)                       gap_q <= 3'd1;
    else if (gap_q < 3'(dcb_pkg::TCCD))    gap_q <= gap_q + 3'd1;
  end

  AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (gap_q >= 3'(dcb_pkg::TCCD))); // R8
  AST_CL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cl_ok_q |-> (cl_q >= CLW'(CL_MIN) && cl_q <= CLW'(CL_MAX))); // R5
  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_ok_q |=> $stable(wptr_q)); // R6
endmodule

// File: tb/test_dram_col_burst.sv
`timescale 1ns/1ps
module test_dram_col_burst;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cfg_cl;
  logic        ld_en;
  logic [5:0]  ld_addr;
  logic [15:0] ld_data;
  logic        rd_valid;
  logic [5:0]  rd_col;
  logic        rd_chop;
  logic [15:0] dq_even, dq_odd;
  logic        dq_even_vld, dq_odd_vld;

  always #4 clk = ~clk;  // 125 MHz

  dram_col_burst i_dram_col_burst (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_valid(rd_valid), .rd_col(rd_col), .rd_chop(rd_chop),
    .dq_even(dq_even), .dq_even_vld(dq_even_vld), .dq_odd(dq_odd), .dq_odd_vld(dq_odd_vld)
  );

  typedef struct {
    int          cyc;
    logic [15:0] ev;
    logic [15:0] od;
    string       tag;
  } beat_t;

  beat_t       sb[$];
  logic [15:0] model [64];
  int          cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;
  int          cl_eff = 5;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int word_at(input int col, input int pos);
    int s;
    s = col & 7;
    return (col & ~7) | ((((s >> 2) ^ (pos >> 2)) & 1) << 2) | ((s + pos) & 3);
  endfunction

  // monitor: compares every cycle while enabled
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (sb.size() > 0 && sb[0].cyc == cyc) begin
        beat_t b;
        b = sb.pop_front();
        n_run++;
        if (!(dq_even_vld && dq_odd_vld && dq_even == b.ev && dq_odd == b.od)) begin
          n_fail++;
          $display("FAIL %s cyc %0d: got vld=%b%b %h/%h exp vld=11 %h/%h",
                   b.tag, cyc, dq_even_vld, dq_odd_vld, dq_even, dq_odd, b.ev, b.od);
        end
      end else if (dq_even_vld || dq_odd_vld) begin
        n_run++;
        n_fail++;
        $display("FAIL R6 R9 cyc %0d: got vld=%b%b exp vld=00", cyc, dq_even_vld, dq_odd_vld);
      end
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    ld_en = 1'b1; ld_addr = 6'(a); ld_data = d;
    model[a] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // driver: issue a read, push expected beats, wait the spacing
  task automatic rd(input int col, input bit chop, input int gap, input string tag);
    int nb;
    nb = chop ? 2 : 4;
    rd_valid = 1'b1; rd_col = 6'(col); rd_chop = chop;
    for (int b = 0; b < nb; b++) begin
      beat_t it;
      it.cyc = cyc + 1 + cl_eff + b;
      it.ev  = model[word_at(col, 2*b)];
      it.od  = model[word_at(col, 2*b + 1)];
      it.tag = tag;
      sb.push_back(it);
    end
    @(negedge clk);
    rd_valid = 1'b0;
    for (int k = 1; k < gap; k++) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input int cfg, input int eff, input bit rd_at_release);
    mon_on = 1'b0;
    rst_n = 1'b0; cfg_cl = 5'(cfg);
    repeat (2) @(negedge clk);
    n_run++;
    if (dq_even_vld || dq_odd_vld) begin
      n_fail++;
      $display("FAIL R9 reset: got vld=%b%b exp vld=00", dq_even_vld, dq_odd_vld);
    end
    cl_eff = eff;
    rd_valid = rd_at_release; rd_col = 6'd9; rd_chop = 1'b0;
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    repeat (cl_eff + 6) @(negedge clk);  // R6: any output here is flagged
  endtask

  initial begin
    ld_en = 0; ld_addr = 0; ld_data = 0; rd_valid = 0; rd_col = 0; rd_chop = 0;
    rst_n = 0; cfg_cl = 5'd9;
    @(negedge clk);
    // phase A: CL 9, read at capture edge ignored (R6), then cfg change ignored (R5)
    do_reset(9, 9, 1'b1);
    cfg_cl = 5'd12;
    for (int a = 0; a < 64; a++) wr(a, 16'(a * 16'h0131 + 16'h2C05));
    for (int s = 0; s < 8; s++) rd(8 * s + s, 1'b0, 4, "R1 R2 R3 R5 R8");
    drain();
    for (int s = 0; s < 8; s++) rd(8 * (7 - s) + s, 1'b1, 4, "R2 R4 R8");
    drain();
    rd(13, 1'b0, 6, "R2 R3");
    rd(22, 1'b1, 5, "R4");
    // R7: overwrite the chunk right after the read is accepted
    rd(45, 1'b0, 1, "R7");
    for (int a = 40; a < 48; a++) wr(a, ~model[a]);
    drain();
    rd(45, 1'b0, 4, "R1 R7");
    rd(3, 1'b1, 4, "R4 R8");
    rd(60, 1'b0, 4, "R8");
    drain();
    // phase B: low setting clamps to 5
    do_reset(3, 5, 1'b0);
    for (int s = 0; s < 8; s++) rd(8 * ((s + 3) & 7) + s, s[0], 4, "R2 R5");
    drain();
    // phase C: high setting clamps to 16, four reads in flight
    do_reset(25, 16, 1'b0);
    for (int s = 0; s < 8; s++) rd(8 * s + (7 - s), s[1], 4, "R5 R8");
    drain();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule